// File: doc/BRIEF.md
# Polyphase Decimating FIR Filter

This block low-pass filters a sample stream and keeps one output for every `DECIM` accepted inputs. Only the decimated outputs are ever computed. The `DECIM*TAPS_PER_PHASE` coefficient taps are split into `DECIM` sub-filters, also called phases. Phase `k` holds the taps `h(k + n*DECIM)` for `n = 0..TAPS_PER_PHASE-1`.

A rotating distributor passes each accepted input sample to one phase. Each phase keeps a short delay line of its own, and that delay line moves only when the phase receives a sample. When a group of `DECIM` samples is complete, every phase forms its product-sum once. The phase sums are added at full precision, rounded, saturated and presented as one output word with a one-cycle valid strobe.

The input is a plain valid-qualified stream. Gaps between samples are allowed, and the output rate is one `DECIM`-th of the accepted-sample rate. The coefficients are fixed when the design is built. A synchronous reset returns the filter to an empty state.

Top module: `polyphase_decimator`

## Requirements
- R1: While `rst` is high and in the cycle after it, `out_valid` is 0 and `out_data` is 0.
- R2: Let x(i) be the i-th sample accepted since reset, counting from 0. Output number m carries y(m) = sum over j = 0..DECIM*TAPS_PER_PHASE-1 of h(j)*x(m*DECIM + DECIM-1 - j), taken from the FIR sum at input index m*DECIM + DECIM-1. The result is the same as a full-rate FIR that keeps every DECIM-th result.
- R3: The coefficient set is h(i) = 3000 - 375*i for i = 0..15, with default parameters DECIM=4 and TAPS_PER_PHASE=4. Within each group, the first sample goes to phase DECIM-1 and the last sample goes to phase 0.
- R4: An output is produced only when the last sample of a group is accepted. `out_valid` rises exactly one clock edge after the accepting edge and stays high for exactly one cycle.
- R5: No output appears until DECIM*TAPS_PER_PHASE samples have been accepted. The first output follows the sample that fills the last tap.
- R6: A cycle with `in_valid` low has no effect. No phase delay line moves, the distributor does not advance, and `out_data` keeps its value until the next output.
- R7: The full-precision sum is scaled by 2^-FRAC_SHIFT (default 13), rounding to nearest with ties toward +infinity. For example, a sum of 1536000 gives 188 and a sum of -1536000 gives -187.
- R8: Scaled results outside the range of a signed OUT_W-bit word (default 16 bits, range -32768..32767) are clamped to the nearest limit.
- R9: A reset in the middle of the stream clears every delay line and restarts the distributor at phase DECIM-1. After the reset, outputs follow R2 and R5 using only post-reset samples.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample is accepted on this edge |
| in_data | input | DATA_W | Signed two's-complement input sample |
| out_valid | output | 1 | One-cycle strobe marking a new decimated output |
| out_data | output | OUT_W | Signed, rounded and saturated filter output |

## Verification
The hardest situations to reach from the ports are the exact rounding tie and the saturation limits. Random data almost never produces a full-precision sum sitting exactly halfway between two output codes, or a sum large enough to clip. The stimulus therefore includes directed sequences. A single sample of ±512 at the newest tap produces the half-code sum in both signs. A sample pattern that matches the sign of each coefficient drives the result beyond both rails. A reset issued partway through a group shows whether the distributor realigns, because any leftover phase offset or stale delay-line content changes every later output.

// File: rtl/polydec_pkg.sv
package polydec_pkg;

    localparam int DEF_DECIM          = 4;
    localparam int DEF_TAPS_PER_PHASE = 4;
    localparam int DEF_DATA_W         = 16;
    localparam int DEF_COEF_W         = 16;
    localparam int DEF_OUT_W          = 16;
    localparam int DEF_FRAC_SHIFT     = 13;

    // Events seen by the sample distributor in one cycle.
    typedef struct packed {
        logic accept;      // a sample is taken this cycle
        logic group_done;  // the sample goes to phase 0 and closes a group
        logic primed;      // enough whole groups seen to fill every tap
    } comm_evt_t;

    // Prototype coefficient h(idx) as a signed integer.
    function automatic int tap_coef(input int idx);
        return 3000 - 375 * idx;
    endfunction

endpackage

// File: rtl/polydec_commutator.sv
module polydec_commutator
    import polydec_pkg::*;
#(
    parameter int DECIM          = DEF_DECIM,
    parameter int TAPS_PER_PHASE = DEF_TAPS_PER_PHASE
)
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    output logic [DECIM-1:0] shift_en,
    output logic             fire
);

    localparam int PTR_W = (DECIM > 1) ? $clog2(DECIM) : 1;
    localparam int GRP_W = $clog2(TAPS_PER_PHASE + 1);
    localparam logic [PTR_W-1:0] PTR_FIRST = PTR_W'(DECIM - 1);
    localparam logic [GRP_W-1:0] GRP_FULL  = GRP_W'(TAPS_PER_PHASE);
    localparam logic [GRP_W-1:0] GRP_PRIME = GRP_W'(TAPS_PER_PHASE - 1);

    logic [PTR_W-1:0] ptr_q;
    logic [GRP_W-1:0] grp_q;
    comm_evt_t        evt;

    always_comb begin
        evt.accept     = in_valid;
        evt.group_done = in_valid && (ptr_q == '0);
        evt.primed     = (grp_q >= GRP_PRIME);
    end

    generate
        for (genvar b = 0; b < DECIM; b++) begin : g_sel
            assign shift_en[b] = evt.accept && (ptr_q == PTR_W'(b));
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= PTR_FIRST;
            grp_q <= '0;
            fire  <= 1'b0;
        end else begin
            fire <= evt.group_done && evt.primed;
            if (evt.accept) begin
                ptr_q <= (ptr_q == '0) ? PTR_FIRST : ptr_q - PTR_W'(1);
            end
            if (evt.group_done && (grp_q != GRP_FULL)) begin
                grp_q <= grp_q + GRP_W'(1);
            end
        end
    end

endmodule

// File: rtl/polydec_branch.sv
module polydec_branch
    import polydec_pkg::*;
#(
    parameter int DECIM  = DEF_DECIM,
    parameter int TAPS   = DEF_TAPS_PER_PHASE,
    parameter int PHASE  = 0,
    parameter int DATA_W = DEF_DATA_W,
    parameter int COEF_W = DEF_COEF_W,
    parameter int SUM_W  = DATA_W + COEF_W + $clog2(TAPS) + 1
)
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     shift_en,
    input  logic signed [DATA_W-1:0] din,
    output logic signed [SUM_W-1:0]  psum
);

    localparam int PROD_W = DATA_W + COEF_W;

    logic signed [DATA_W-1:0] line_q [TAPS];

    // Delay line of this phase: moves only when the phase is fed.
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < TAPS; i++) begin
                line_q[i] <= '0;
            end
        end else if (shift_en) begin
            line_q[0] <= din;
            for (int i = 1; i < TAPS; i++) begin
                line_q[i] <= line_q[i-1];
            end
        end
    end

    // Tap n of this phase uses h(PHASE + n*DECIM).
    always_comb begin
        logic signed [COEF_W-1:0] c;
        logic signed [PROD_W-1:0] prod;
        psum = '0;
        for (int n = 0; n < TAPS; n++) begin
            c    = COEF_W'(tap_coef(PHASE + n * DECIM));
            prod = line_q[n] * c;
            psum = psum + SUM_W'(prod);
        end
    end

endmodule

// File: rtl/polydec_combine.sv
module polydec_combine
    import polydec_pkg::*;
#(
    parameter int DECIM      = DEF_DECIM,
    parameter int SUM_W      = 34,
    parameter int ACC_W      = SUM_W + $clog2(DECIM) + 1,
    parameter int OUT_W      = DEF_OUT_W,
    parameter int FRAC_SHIFT = DEF_FRAC_SHIFT
)
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    fire,
    input  logic signed [SUM_W-1:0] psum [DECIM],
    output logic                    out_valid,
    output logic signed [OUT_W-1:0] out_data
);

    localparam logic signed [ACC_W-1:0] HALF    = ACC_W'(1) << (FRAC_SHIFT - 1);
    localparam logic signed [ACC_W-1:0] OUT_MAX =
        {{(ACC_W - OUT_W + 1){1'b0}}, {(OUT_W - 1){1'b1}}};
    localparam logic signed [ACC_W-1:0] OUT_MIN =
        {{(ACC_W - OUT_W + 1){1'b1}}, {(OUT_W - 1){1'b0}}};

    logic signed [ACC_W-1:0] total;
    logic signed [ACC_W-1:0] scaled;
    logic signed [OUT_W-1:0] clipped;

    always_comb begin
        total = '0;
        for (int k = 0; k < DECIM; k++) begin
            total = total + ACC_W'(psum[k]);
        end
        scaled = (total + HALF) >>> FRAC_SHIFT;
        if (scaled > OUT_MAX) begin
            clipped = OUT_MAX[OUT_W-1:0];
        end else if (scaled < OUT_MIN) begin
            clipped = OUT_MIN[OUT_W-1:0];
        end else begin
            clipped = scaled[OUT_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= fire;
            if (fire) begin
                out_data <= clipped;
            end
        end
    end

endmodule

// File: rtl/polyphase_decimator.sv
module polyphase_decimator
    import polydec_pkg::*;
#(
    parameter int DECIM          = DEF_DECIM,
    parameter int TAPS_PER_PHASE = DEF_TAPS_PER_PHASE,
    parameter int DATA_W         = DEF_DATA_W,
    parameter int COEF_W         = DEF_COEF_W,
    parameter int OUT_W          = DEF_OUT_W,
    parameter int FRAC_SHIFT     = DEF_FRAC_SHIFT
)
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    input  logic signed [DATA_W-1:0] in_data,
    output logic                     out_valid,
    output logic signed [OUT_W-1:0]  out_data
);

    localparam int SUM_W = DATA_W + COEF_W + $clog2(TAPS_PER_PHASE) + 1;
    localparam int ACC_W = SUM_W + $clog2(DECIM) + 1;

    logic [DECIM-1:0]        shift_en;
    logic                    fire;
    logic signed [SUM_W-1:0] psum [DECIM];

    polydec_commutator #(
        .DECIM          (DECIM),
        .TAPS_PER_PHASE (TAPS_PER_PHASE)
    ) u_comm (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .shift_en (shift_en),
        .fire     (fire)
    );

    generate
        for (genvar k = 0; k < DECIM; k++) begin : g_phase
            polydec_branch #(
                .DECIM  (DECIM),
                .TAPS   (TAPS_PER_PHASE),
                .PHASE  (k),
                .DATA_W (DATA_W),
                .COEF_W (COEF_W),
                .SUM_W  (SUM_W)
            ) u_branch (
                .clk      (clk),
                .rst      (rst),
                .shift_en (shift_en[k]),
                .din      (in_data),
                .psum     (psum[k])
            );
        end
    endgenerate

    polydec_combine #(
        .DECIM      (DECIM),
        .SUM_W      (SUM_W),
        .ACC_W      (ACC_W),
        .OUT_W      (OUT_W),
        .FRAC_SHIFT (FRAC_SHIFT)
    ) u_comb (
        .clk       (clk),
        .rst       (rst),
        .fire      (fire),
        .psum      (psum),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

endmodule

// File: rtl/polydec_checker.sv
module polydec_checker #(
    parameter int DECIM          = 4,
    parameter int TAPS_PER_PHASE = 4,
    parameter int OUT_W          = 16
)
(
    input logic                    clk,
    input logic                    rst,
    input logic                    in_valid,
    input logic                    out_valid,
    input logic signed [OUT_W-1:0] out_data
);

    localparam int TOTAL = DECIM * TAPS_PER_PHASE;
    localparam int CNT_W = $clog2(TOTAL + 1);

    logic [CNT_W-1:0] seen_q;
    logic             rst_q = 1'b1;

    always @(posedge clk) begin
        rst_q <= rst;
        if (rst) begin
            seen_q <= '0;
        end else if (in_valid && (seen_q != CNT_W'(TOTAL))) begin
            seen_q <= seen_q + CNT_W'(1);
        end
    end

    always @(posedge clk) begin
        if (rst_q) begin
            AST_RESET_IDLE: assert (!out_valid); // R1
        end
    end

    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid); // R4

    AST_OUT_AFTER_INPUT: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid, 2)); // R4

    AST_FILL_FIRST: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (seen_q == CNT_W'(TOTAL))); // R5

    AST_HOLD_DATA: assert property (@(posedge clk) disable iff (rst)
        (!out_valid && !rst_q) |-> $stable(out_data)); // R6

endmodule

bind polyphase_decimator polydec_checker #(
    .DECIM          (DECIM),
    .TAPS_PER_PHASE (TAPS_PER_PHASE),
    .OUT_W          (OUT_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .out_data  (out_data)
);

// File: tb/polyphase_decimator_tb.sv
module polyphase_decimator_tb;

    localparam int D     = 4;
    localparam int K     = 4;
    localparam int DK    = D * K;
    localparam int DW    = 16;
    localparam int OW    = 16;
    localparam int SHIFT = 13;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 in_valid = 1'b0;
    logic signed [DW-1:0] in_data = '0;
    logic                 out_valid;
    logic signed [OW-1:0] out_data;

    polyphase_decimator u_dut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    always #2 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int    n_checks = 0;
    int    n_errors = 0;
    int    n_out    = 0;
    int    hist[$];
    int    exp_val[$];
    int    exp_at[$];
    string exp_tag[$];
    string cur_req = "R1";
    bit    done = 1'b0;

    function automatic int h_of(input int i);
        return 3000 - 375 * i;
    endfunction

    function automatic int model_out();
        longint acc = 0;
        int     n   = hist.size();
        for (int j = 0; j < DK; j++) begin
            acc += longint'(h_of(j)) * longint'(hist[n-1-j]);
        end
        acc = (acc + (longint'(1) << (SHIFT - 1))) >>> SHIFT;
        if (acc > 32767)  acc = 32767;
        if (acc < -32768) acc = -32768;
        return int'(acc);
    endfunction

    task automatic check(input string tag, input int act, input int expv);
        n_checks++;
        if (act !== expv) begin
            n_errors++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, expv, cyc);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    endtask

    task automatic push_sample(input int x);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = DW'(x);
        hist.push_back(x);
        if ((hist.size() % D == 0) && (hist.size() >= DK)) begin
            exp_val.push_back(model_out());
            exp_at.push_back(cyc + 2);
            exp_tag.push_back(cur_req);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst      = 1'b1;
        in_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R1 out_valid in reset", int'(out_valid), 0);
        check("R1 out_data in reset", int'(out_data), 0);
        rst = 1'b0;
        hist.delete();
    endtask

    // Output monitor: every strobe must match a queued expectation.
    always @(negedge clk) begin
        if (out_valid) begin
            n_out++;
            if (exp_val.size() == 0) begin
                check({cur_req, " R4 unexpected output"}, 1, 0);
            end else begin
                check({exp_tag[0], " value"}, int'(out_data), exp_val[0]);
                check("R4 output cycle", cyc, exp_at[0]);
                void'(exp_val.pop_front());
                void'(exp_at.pop_front());
                void'(exp_tag.pop_front());
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_errors++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            summary();
            $finish;
        end
    end

    initial begin
        int seed;
        int snap;
        seed = $urandom(32'd20240611);

        // R1: reset state
        do_reset();
        @(negedge clk);
        check("R1 out_valid after reset", int'(out_valid), 0);
        check("R1 out_data after reset", int'(out_data), 0);

        // R5: nothing until every tap holds a sample
        cur_req = "R5";
        for (int i = 0; i < DK - 1; i++) push_sample(100 * (i + 1));
        idle(4);
        check("R5 no output before fill", n_out, 0);
        push_sample(-700);
        idle(4);
        check("R5 first output after fill", n_out, 1);

        // R3: impulse placed at each offset inside a group exposes every tap
        cur_req = "R3";
        for (int off = 0; off < D; off++) begin
            do_reset();
            for (int i = 0; i < off; i++) push_sample(0);
            push_sample(8192);
            for (int i = 0; i < 2 * DK + D - 1 - off; i++) push_sample(0);
            idle(4);
        end

        // R2: back-to-back full-range random stream
        do_reset();
        cur_req = "R2";
        for (int i = 0; i < 400; i++) push_sample(int'($urandom_range(65535)) - 32768);
        idle(4);

        // R6: random gaps, plus a long pause inside a group
        cur_req = "R6";
        for (int i = 0; i < 300; i++) begin
            push_sample(int'($urandom_range(20000)) - 10000);
            if ($urandom_range(3) == 0) idle(int'($urandom_range(4)) + 1);
        end
        push_sample(1234);
        push_sample(-4321);
        idle(3);
        snap = n_out;
        idle(12);
        check("R6 idle cycles produce no output", n_out, snap);
        for (int i = 0; i < 2 * DK; i++) push_sample(int'($urandom_range(2000)) - 1000);
        idle(4);

        // R7: exact half-code ties in both signs, then small-amplitude noise
        cur_req = "R7";
        do_reset();
        for (int i = 0; i < DK - 1; i++) push_sample(0);
        push_sample(512);
        idle(4);
        do_reset();
        for (int i = 0; i < DK - 1; i++) push_sample(0);
        push_sample(-512);
        idle(4);
        for (int i = 0; i < 200; i++) push_sample(int'($urandom_range(16)) - 8);
        idle(4);

        // R8: sign-matched pattern drives both rails
        cur_req = "R8";
        do_reset();
        for (int j = DK - 1; j >= 0; j--) push_sample((h_of(j) >= 0) ? 32767 : -32768);
        for (int j = DK - 1; j >= 0; j--) push_sample((h_of(j) >= 0) ? -32768 : 32767);
        idle(4);

        // R9: reset partway through a group, then a fresh stream
        cur_req = "R2";
        for (int i = 0; i < 10; i++) push_sample(int'($urandom_range(65535)) - 32768);
        idle(4);
        do_reset();
        cur_req = "R9";
        snap = n_out;
        for (int i = 0; i < DK - 1; i++) push_sample(int'($urandom_range(65535)) - 32768);
        idle(3);
        check("R9 no output before refill", n_out, snap);
        for (int i = 0; i < 3 * DK + 1; i++) push_sample(int'($urandom_range(65535)) - 32768);
        idle(6);

        check("R4 all expected outputs seen", exp_val.size(), 0);
        done = 1'b1;
        summary();
        $finish;
    end

endmodule